// File: doc/BRIEF.md
# Four-Channel Quadrature Position Counter with Index Interrupts

This block tracks the shaft position of up to four incremental encoders. Each channel takes the two phase signals and the once-per-revolution index signal of one encoder, already converted to single-ended logic levels. It brings them into the local clock domain through a short synchroniser chain. It then decodes every valid phase transition into a single step of a position counter that is 12 bits wide by default. The counter runs in either direction and wraps cyclically at both ends. A host reads the counters through a small read port that captures a whole count in one clock.

Each channel also detects the rising edge of its index signal and latches a per-channel interrupt flag. The flags are cleared by writing ones to an acknowledge word. A per-channel mask decides which flags drive the single shared interrupt line. The same acknowledge word clears a sticky per-channel error flag. That flag records phase samples in which both phase signals moved at once, which leaves the position ambiguous.

Top module: `quad_enc_array`

## Requirements
- R1: While `rst_n` is low, and right after it rises, every count is 0, all interrupt and error flags are 0, `irq` is 0 and `rd_valid` is 0.
- R2: With the phase pair written as {A,B}, each transition 00→10, 10→11, 11→01 or 01→00 adds one to that channel's count.
- R3: Each transition 00→01, 01→11, 11→10 or 10→00 subtracts one from that channel's count.
- R4: Counting is modulo 2^CNT_W: one step up from all ones gives 0, and one step down from 0 gives all ones. Per clock, a count changes by at most one step.
- R5: A sample in which A and B both change leaves the count unchanged and sets that channel's error flag. The flag stays set until `ack_we` is high with `ack_data` bit NUM_CH+i set. Phase decoding then continues from the new phase pair.
- R6: A rising edge on `enc_z[i]` sets `irq_flags[i]`. The flag stays set while the index stays high, after the index falls, and until it is acknowledged.
- R7: `ack_we` high with `ack_data` bit i set clears `irq_flags[i]` on that clock. Other flags are unaffected.
- R8: `irq` is high exactly when some flag is set whose `irq_mask` bit is 0. A mask bit of 1 blocks that flag from `irq` but leaves the flag itself set.
- R9: `rd_en` high at a clock edge captures the count of channel `rd_sel` into `rd_data`, and `rd_valid` is high for that one following cycle only.
- R10: The channels are independent. Activity on one channel never changes another channel's count or flags.
- R11: A phase change at the pins shows in `pos_flat` after exactly three rising clock edges: two synchroniser stages and one counter update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | NUM_CH | Phase A per channel |
| enc_b | input | NUM_CH | Phase B per channel |
| enc_z | input | NUM_CH | Index phase per channel |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | $clog2(NUM_CH) | Channel to read |
| rd_data | output | CNT_W | Captured count |
| rd_valid | output | 1 | rd_data valid, one cycle after rd_en |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 2*NUM_CH | Low half clears index flags, high half clears error flags |
| irq_mask | input | NUM_CH | 1 blocks a channel from irq |
| irq_flags | output | NUM_CH | Latched index interrupt flags |
| err_flags | output | NUM_CH | Sticky illegal-transition flags |
| irq | output | 1 | Combined interrupt |
| pos_flat | output | NUM_CH*CNT_W | All counts, channel i at bits i*CNT_W upward |

## Verification
The hardest states to reach from the ports are the two wrap boundaries and the illegal double-phase step. The bench reaches the lower boundary with one backward step from reset. It reaches the upper boundary by driving more than a full revolution of forward Gray steps on one channel, 4100 in all, so the counter passes all ones and comes back around. For the illegal case, both phase pins move together at one clock edge. The bench then checks that the count held, that only that channel's error flag rose, and that decoding continues from the new phase pair. Index handling is checked through masking, acknowledgement and a held-high index, with no second flag from the same edge.

// File: rtl/enc_pkg.sv
package enc_pkg;

   typedef enum logic [1:0] {
      MOV_NONE = 2'd0,
      MOV_UP   = 2'd1,
      MOV_DOWN = 2'd2,
      MOV_BAD  = 2'd3
   } move_e;

   // forward Gray successor of the {A,B} pair
   function automatic logic [1:0] gray_fwd(input logic [1:0] s);
      case (s)
         2'b00:   gray_fwd = 2'b10;
         2'b10:   gray_fwd = 2'b11;
         2'b11:   gray_fwd = 2'b01;
         default: gray_fwd = 2'b00;
      endcase
   endfunction

   function automatic move_e classify(input logic [1:0] prev, input logic [1:0] cur);
      if (prev == cur)                  classify = MOV_NONE;
      else if ((prev ^ cur) == 2'b11)   classify = MOV_BAD;
      else if (gray_fwd(prev) == cur)   classify = MOV_UP;
      else                              classify = MOV_DOWN;
   endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("enc_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/enc_channel.sv
module enc_channel
   import enc_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ph_a,
   input  logic             ph_b,
   input  logic             ph_z,
   input  logic             clr_irq,
   input  logic             clr_err,
   output logic [CNT_W-1:0] count,
   output logic             irq_flag,
   output logic             err_flag
);
   if (CNT_W < 2) begin : g_bad_width
      $error("enc_channel: CNT_W must be at least 2");
   end

   logic [1:0] ab_prev;
   logic       z_prev;
   move_e      mv;
   logic       z_rise;

   assign mv     = classify(ab_prev, {ph_a, ph_b});
   assign z_rise = ph_z & ~z_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ab_prev  <= 2'b00;
         z_prev   <= 1'b0;
         count    <= '0;
         irq_flag <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         ab_prev  <= {ph_a, ph_b};
         z_prev   <= ph_z;
         case (mv)
            MOV_UP:   count <= count + 1'b1;
            MOV_DOWN: count <= count - 1'b1;
            default:  count <= count;
         endcase
         irq_flag <= (irq_flag & ~clr_irq) | z_rise;
         err_flag <= (err_flag & ~clr_err) | (mv == MOV_BAD);
      end
   end
endmodule

// File: rtl/enc_readport.sv
module enc_readport #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 12,
   parameter int SEL_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH*CNT_W-1:0] counts,
   input  logic                    rd_en,
   input  logic [SEL_W-1:0]        rd_sel,
   output logic [CNT_W-1:0]        rd_data,
   output logic                    rd_valid
);
   logic [CNT_W-1:0] cnt_arr [NUM_CH];
   logic [CNT_W-1:0] pick;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
      assign cnt_arr[i] = counts[i*CNT_W +: CNT_W];
   end

   always_comb begin
      pick = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (rd_sel == SEL_W'(i)) pick = cnt_arr[i];
      end
   end

   // whole word captured in a single clock
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= pick;
      end
   end
endmodule

// File: rtl/quad_enc_array.sv
module quad_enc_array #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_CH-1:0]          enc_a,
   input  logic [NUM_CH-1:0]          enc_b,
   input  logic [NUM_CH-1:0]          enc_z,
   input  logic                       rd_en,
   input  logic [$clog2(NUM_CH)-1:0]  rd_sel,
   output logic [CNT_W-1:0]           rd_data,
   output logic                       rd_valid,
   input  logic                       ack_we,
   input  logic [2*NUM_CH-1:0]        ack_data,
   input  logic [NUM_CH-1:0]          irq_mask,
   output logic [NUM_CH-1:0]          irq_flags,
   output logic [NUM_CH-1:0]          err_flags,
   output logic                       irq,
   output logic [NUM_CH*CNT_W-1:0]    pos_flat
);
   localparam int SEL_W  = $clog2(NUM_CH);
   localparam int SYNC_W = 3 * NUM_CH;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("quad_enc_array: NUM_CH must be at least 2");
   end

   logic [SYNC_W-1:0] raw_in, sync_out;
   logic [NUM_CH-1:0] a_s, b_s, z_s;
   logic [NUM_CH-1:0] clr_irq, clr_err;

   assign raw_in = {enc_z, enc_b, enc_a};
   assign a_s    = sync_out[NUM_CH-1:0];
   assign b_s    = sync_out[2*NUM_CH-1:NUM_CH];
   assign z_s    = sync_out[3*NUM_CH-1:2*NUM_CH];

   enc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign clr_irq = {NUM_CH{ack_we}} & ack_data[NUM_CH-1:0];
   assign clr_err = {NUM_CH{ack_we}} & ack_data[2*NUM_CH-1:NUM_CH];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      enc_channel #(.CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .ph_a     (a_s[i]),
         .ph_b     (b_s[i]),
         .ph_z     (z_s[i]),
         .clr_irq  (clr_irq[i]),
         .clr_err  (clr_err[i]),
         .count    (pos_flat[i*CNT_W +: CNT_W]),
         .irq_flag (irq_flags[i]),
         .err_flag (err_flags[i])
      );
   end

   assign irq = |(irq_flags & ~irq_mask);

   enc_readport #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .counts   (pos_flat),
      .rd_en    (rd_en),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );
endmodule

// File: rtl/quad_enc_array_chk.sv
module quad_enc_array_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    rd_en,
   input logic                    rd_valid,
   input logic                    ack_we,
   input logic [2*NUM_CH-1:0]     ack_data,
   input logic [NUM_CH-1:0]       irq_mask,
   input logic [NUM_CH-1:0]       irq_flags,
   input logic [NUM_CH-1:0]       err_flags,
   input logic                    irq,
   input logic [NUM_CH*CNT_W-1:0] pos_flat
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [CNT_W-1:0] prev_q, delta;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= pos_flat[i*CNT_W +: CNT_W];
      end
      assign delta = pos_flat[i*CNT_W +: CNT_W] - prev_q;

      a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
         (delta == '0) || (delta == CNT_W'(1)) || (delta == '1));

      a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_flags[i] && !(ack_we && ack_data[i])) |=> irq_flags[i]);

      a_r5_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (err_flags[i] && !(ack_we && ack_data[NUM_CH+i])) |=> err_flags[i]);
   end

   a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_flags & ~irq_mask) == '0) |-> !irq);

   a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_flags & ~irq_mask) != '0) |-> irq);

   a_r9_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
endmodule

bind quad_enc_array quad_enc_array_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .rd_valid  (rd_valid),
   .ack_we    (ack_we),
   .ack_data  (ack_data),
   .irq_mask  (irq_mask),
   .irq_flags (irq_flags),
   .err_flags (err_flags),
   .irq       (irq),
   .pos_flat  (pos_flat)
);

// File: tb/quad_enc_array_tb_top.sv
module quad_enc_array_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CW  = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  enc_a = '0, enc_b = '0, enc_z = '0;
   logic            rd_en = 1'b0;
   logic [1:0]      rd_sel = '0;
   logic [CW-1:0]   rd_data;
   logic            rd_valid;
   logic            ack_we = 1'b0;
   logic [2*NCH-1:0] ack_data = '0;
   logic [NCH-1:0]  irq_mask = '0;
   logic [NCH-1:0]  irq_flags, err_flags;
   logic            irq;
   logic [NCH*CW-1:0] pos_flat;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct { int ch; logic [CW-1:0] val; string req; } rd_item_t;
   rd_item_t sb_q [$];

   logic [1:0]    ab_st  [NCH];
   logic [CW-1:0] exp_cnt [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_enc_array #(.NUM_CH(NCH), .CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_z(enc_z),
      .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
      .ack_we(ack_we), .ack_data(ack_data), .irq_mask(irq_mask),
      .irq_flags(irq_flags), .err_flags(err_flags), .irq(irq), .pos_flat(pos_flat)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] cnt_of(input int ch);
      return pos_flat[ch*CW +: CW];
   endfunction

   function automatic logic [1:0] fwd(input logic [1:0] s);
      case (s)
         2'b00: return 2'b10;
         2'b10: return 2'b11;
         2'b11: return 2'b01;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [1:0] bwd(input logic [1:0] s);
      case (s)
         2'b00: return 2'b01;
         2'b01: return 2'b11;
         2'b11: return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

   // drive a phase pair at a falling edge, then wait three rising edges
   task automatic drive_ab(input int ch, input logic [1:0] ab);
      @(negedge clk);
      enc_a[ch] = ab[1];
      enc_b[ch] = ab[0];
      ab_st[ch] = ab;
      repeat (3) @(negedge clk);
   endtask

   task automatic step_up(input int ch);
      exp_cnt[ch] = exp_cnt[ch] + 1'b1;
      drive_ab(ch, fwd(ab_st[ch]));
   endtask

   task automatic step_dn(input int ch);
      exp_cnt[ch] = exp_cnt[ch] - 1'b1;
      drive_ab(ch, bwd(ab_st[ch]));
   endtask

   // scoreboard driver: push expectation, then strobe a read
   task automatic read_push(input int ch, input string req);
      rd_item_t it;
      it.ch = ch; it.val = exp_cnt[ch]; it.req = req;
      @(negedge clk);
      sb_q.push_back(it);
      rd_en  = 1'b1;
      rd_sel = 2'(ch);
      @(negedge clk);
      rd_en  = 1'b0;
      @(negedge clk);
      chk("R9 rd_valid single cycle", {31'd0, rd_valid}, 32'd0);
   endtask

   task automatic ack(input logic [2*NCH-1:0] v);
      @(negedge clk);
      ack_we = 1'b1; ack_data = v;
      @(negedge clk);
      ack_we = 1'b0; ack_data = '0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R9: unexpected rd_valid actual=%0h expected=none", rd_data);
         end else begin
            rd_item_t it;
            it = sb_q.pop_front();
            chk($sformatf("%s ch%0d read", it.req, it.ch), {20'd0, rd_data}, {20'd0, it.val});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin ab_st[i] = 2'b00; exp_cnt[i] = '0; end
      repeat (4) @(negedge clk);
      chk("R1 counts in reset", pos_flat, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 counts after reset", pos_flat, '0);
      chk("R1 irq flags", irq_flags, '0);
      chk("R1 err flags", err_flags, '0);
      chk("R1 irq", irq, 0);
      chk("R1 rd_valid", rd_valid, 0);

      // R11 latency: two edges no change, third edge updated
      @(negedge clk);
      enc_a[0] = 1'b1; ab_st[0] = 2'b10; exp_cnt[0] = 1;
      repeat (2) @(negedge clk);
      chk("R11 after two edges", cnt_of(0), 0);
      @(negedge clk);
      chk("R11 after three edges", cnt_of(0), 1);

      // R2 forward steps
      for (int k = 0; k < 5; k++) step_up(0);
      chk("R2 forward count", cnt_of(0), 6);
      read_push(0, "R2");

      // R3 backward steps, crossing zero (R4)
      for (int k = 0; k < 3; k++) step_dn(1);
      chk("R3 backward count", cnt_of(1), 12'hFFD);
      read_push(1, "R3");
      chk("R10 ch0 untouched", cnt_of(0), 6);

      // R4 boundaries on ch2
      step_dn(2);
      chk("R4 zero minus one", cnt_of(2), 12'hFFF);
      step_up(2);
      chk("R4 all ones plus one", cnt_of(2), 0);

      // R4 a full revolution plus four on ch3
      for (int k = 0; k < 4100; k++) step_up(3);
      read_push(3, "R4");
      chk("R4 wrap after 4100 steps", cnt_of(3), 4);

      // R5 illegal double change on ch2 (state 00 -> 11)
      chk("R5 ch2 state before", {30'd0, ab_st[2]}, 0);
      drive_ab(2, 2'b11);
      chk("R5 count held", cnt_of(2), 0);
      chk("R5 err flag set only ch2", err_flags, 4'b0100);
      step_up(2);
      chk("R5 decode resumes", cnt_of(2), 1);
      chk("R5 err sticky", err_flags[2], 1);
      ack(8'b0100_0000);
      chk("R5 err cleared", err_flags, '0);

      // R6 index edge on ch3
      @(negedge clk); enc_z[3] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 flag set", irq_flags, 4'b1000);
      chk("R8 irq unmasked", irq, 1);
      chk("R10 ch3 count unchanged by index", cnt_of(3), 4);
      irq_mask[3] = 1'b1;
      @(negedge clk);
      chk("R8 irq masked", irq, 0);
      chk("R8 flag kept while masked", irq_flags[3], 1);
      irq_mask[3] = 1'b0;
      enc_z[3] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 flag kept after index falls", irq_flags[3], 1);
      ack(8'b0000_0001);
      chk("R7 wrong bit leaves flag", irq_flags[3], 1);
      ack(8'b0000_1000);
      chk("R7 flag cleared", irq_flags, '0);
      chk("R8 irq low after ack", irq, 0);

      // R6 held-high index, acknowledged once, no retrigger
      @(negedge clk); enc_z[1] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R6 ch1 flag set", irq_flags, 4'b0010);
      ack(8'b0000_0010);
      repeat (4) @(negedge clk);
      chk("R6 held index no retrigger", irq_flags, '0);
      chk("R10 ch1 count kept", cnt_of(1), 12'hFFD);

      repeat (3) @(negedge clk);
      chk("R9 scoreboard drained", sb_q.size(), 0);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule